// File: doc/BRIEF.md
# UART Host Register File with Receive Queue

This block is the processor-facing side of a 16550-style serial port. A host reaches it through an offset bus with separate read and write strobes. It holds the divisor, interrupt enable, FIFO control, line control, modem control and scratch registers. It reports line status, modem status and a prioritized interrupt identity, and it drives one level-sensitive interrupt line. Received characters arrive on a push port and are stored in a receive queue. Characters written by the host leave on a one-cycle strobe-and-data port. Baud timing and serial shifting sit outside the block.

The receive queue holds one entry in the default character mode. It grows to its full depth when the host enables FIFO mode, and any change of that mode empties it. An internal loopback mode sends host writes back into the block's own receive queue. In that mode characters from the external push port are thrown away and the modem status inputs follow the modem control outputs.

Read data is combinational from the current state while the read strobe is high. Read side effects (popping the queue, clearing flags) happen at the clock edge that ends the access.

Top module: `uart_regif`

## Requirements
- R1: Offsets 0..7 select registers and any offset above 7 reads 0x00 and ignores writes. When line-control bit 7 (divisor access) is set, offsets 0 and 1 read and write the divisor low and high bytes in place of data and interrupt enable. Line control (offset 3) and scratch (offset 7) read back what was written.
- R2: The interrupt enable register (offset 1) keeps only written bits 3:0, and bits 7:4 read as 0. Bit 0 enables receive data, bit 1 transmit empty, bit 2 line status and bit 3 modem status.
- R3: The identity code in bits 3:0 of offset 2 is chosen by fixed priority from live conditions, highest first: overrun with line enable gives 0x6, queue not empty with receive enable gives 0x4, transmit-empty flag with transmit enable gives 0x2, any modem delta with modem enable gives 0x0. Otherwise the code is 0x1 (nothing pending).
- R4: A data write sets the transmit-empty flag. A read of offset 2 that returns code 0x2 clears it.
- R5: Bits 7:6 of offset 2 read as 11 while FIFO mode is enabled and as 00 otherwise.
- R6: The line status register (offset 5) always has bits 6 and 5 set. Bit 0 is set when the queue holds a byte and bit 1 is the overrun flag. A line status read clears the overrun flag, except that an overrun set in the same cycle wins.
- R7: A FIFO control write (offset 2) whose bit 0 differs from the stored enable empties the queue and sets its capacity: the full depth (16) when enabling and 1 entry when disabling.
- R8: A FIFO control write with bit 0 clear ignores its other bits. A write with bit 0 set and bit 1 set empties the queue without changing its capacity.
- R9: After reset the divisor reads 12 (input clock / baud / 16), every other writable register is 0, the modem status reads 0xA0, and the queue capacity is 1.
- R10: With modem-control bit 4 (loopback) set, a data write goes into the receive queue and not to the transmit port, and external pushes are discarded without setting overrun.
- R11: A push into a full queue is dropped and sets the overrun flag. A push and a data read in the same cycle on a full queue are both accepted. Bytes leave in arrival order.
- R12: The interrupt output is high exactly when the current identity code is not 0x1.
- R13: Outside loopback, a data write drives the transmit strobe high for one cycle after the write edge, with the written byte on the transmit data port.
- R14: Modem status bits 7:4 are {DCD, RI, DSR, CTS}. They read 1010 outside loopback. In loopback they are {mcr[3], mcr[2], mcr[0], mcr[1]}. A modem control write sets delta bits 0 (CTS changed), 1 (DSR changed), 3 (DCD changed) and 2 (RI fell). A modem status read clears the delta bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe, side effects taken at the clock edge |
| rdata_o | output | 8 | Combinational read data for addr_i |
| rx_push_i | input | 1 | External received-byte push |
| rx_data_i | input | 8 | External received byte |
| tx_valid_o | output | 1 | Transmit strobe, one cycle per written byte |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt request |

## Verification
A data read that pops the queue can fall in the same cycle as a push. The bench fills the one-entry queue, then raises the read strobe and the push strobe in a single cycle. It expects the old byte on the read, no overrun, and the new byte on the next read. A line status read can also coincide with a push that overflows the queue. The bench issues both together and expects the following line status read to still show the overrun bit, because the set must win over the clear-on-read.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_IIR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  localparam int unsigned LCR_DIV_BIT  = 7;
  localparam int unsigned MCR_LOOP_BIT = 4;
  localparam logic [7:0]  FCR_KEEP     = 8'hC9;

  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_THRE  = 4'h2,
    IID_RXDAT = 4'h4,
    IID_LINE  = 4'h6
  } iid_e;

  // modem input nibble {DCD, RI, DSR, CTS} seen for a given modem control value
  function automatic logic [3:0] modem_lines(input logic [4:0] mcr);
    modem_lines = mcr[MCR_LOOP_BIT] ? {mcr[3], mcr[2], mcr[0], mcr[1]} : 4'b1010;
  endfunction
endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          big_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] cap_o,
  output logic          drop_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wptr_q, rptr_q, cnt_q, cap_q;
  logic          pop_ok, push_ok;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] p, input logic [CW-1:0] cap);
    bump = (p == cap - 1'b1) ? '0 : p + 1'b1;
  endfunction

  assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;
  assign push_ok = push_i && !flush_i && ((cnt_q < cap_q) || pop_ok);
  assign drop_o  = push_i && !flush_i && !push_ok;
  assign head_o  = mem[rptr_q[PW-1:0]];
  assign count_o = cnt_q;
  assign cap_o   = cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      cap_q  <= CW'(1);
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      cap_q  <= big_i ? CW'(DEPTH) : CW'(1);
    end else begin
      if (push_ok) wptr_q <= bump(wptr_q, cap_q);
      if (pop_ok)  rptr_q <= bump(rptr_q, cap_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wptr_q[PW-1:0]] <= data_i;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_regif_pkg::*;
(
  input  logic [3:0] ier_i,
  input  logic       overrun_i,
  input  logic       rx_avail_i,
  input  logic       thre_i,
  input  logic       modem_i,
  output iid_e       iid_o
);
  always_comb begin
    if (overrun_i && ier_i[2])       iid_o = IID_LINE;
    else if (rx_avail_i && ier_i[0]) iid_o = IID_RXDAT;
    else if (thre_i && ier_i[1])     iid_o = IID_THRE;
    else if (modem_i && ier_i[3])    iid_o = IID_MODEM;
    else                             iid_o = IID_NONE;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CLK_HZ    = 1843200,
  parameter int unsigned BAUD      = 9600,
  parameter int unsigned RXQ_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  localparam logic [15:0] DIV_RST = 16'(CLK_HZ / BAUD / 16);
  localparam int unsigned QCW     = $clog2(RXQ_DEPTH + 1);

  logic [7:0]     dll_q, dlh_q, lcr_q, scr_q, fcr_q, tx_data_q;
  logic [3:0]     ier_q, msr_dlt_q;
  logic [4:0]     mcr_q;
  logic           thre_pend_q, oe_q, tx_valid_q;
  logic           hit, dlab, loop_en, fifo_en;
  logic [2:0]     ofs;
  logic           wr_data, rd_data, wr_fcr, rd_iir, rd_lsr, rd_msr, wr_mcr;
  logic           q_flush, q_push, q_drop;
  logic [7:0]     q_din, q_head;
  logic [QCW-1:0] q_count, q_cap;
  logic           q_empty;
  logic [3:0]     lines_now, lines_new, dlt_new;
  iid_e           iid;

  assign hit     = (addr_i[ADDR_W-1:3] == '0);
  assign ofs     = addr_i[2:0];
  assign dlab    = lcr_q[LCR_DIV_BIT];
  assign loop_en = mcr_q[MCR_LOOP_BIT];
  assign fifo_en = fcr_q[0];
  assign q_empty = (q_count == '0);

  assign wr_data = wr_i && hit && ofs == OFS_DATA && !dlab;
  assign rd_data = rd_i && hit && ofs == OFS_DATA && !dlab;
  assign wr_fcr  = wr_i && hit && ofs == OFS_IIR;
  assign rd_iir  = rd_i && hit && ofs == OFS_IIR;
  assign rd_lsr  = rd_i && hit && ofs == OFS_LSR;
  assign rd_msr  = rd_i && hit && ofs == OFS_MSR;
  assign wr_mcr  = wr_i && hit && ofs == OFS_MCR;

  // enable toggle resizes; receive-reset only honoured while the write enables
  assign q_flush = wr_fcr && ((wdata_i[0] != fifo_en) || (wdata_i[0] && wdata_i[1]));
  assign q_push  = loop_en ? wr_data : rx_push_i;
  assign q_din   = loop_en ? wdata_i : rx_data_i;

  uart_rx_queue #(.DEPTH(RXQ_DEPTH), .W(8)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (q_flush),
    .big_i   (wdata_i[0]),
    .push_i  (q_push),
    .data_i  (q_din),
    .pop_i   (rd_data),
    .head_o  (q_head),
    .count_o (q_count),
    .cap_o   (q_cap),
    .drop_o  (q_drop)
  );

  uart_irq_prio u_prio (
    .ier_i      (ier_q),
    .overrun_i  (oe_q),
    .rx_avail_i (!q_empty),
    .thre_i     (thre_pend_q),
    .modem_i    (msr_dlt_q != '0),
    .iid_o      (iid)
  );

  assign irq_o = (iid != IID_NONE);

  assign lines_now = modem_lines(mcr_q);
  assign lines_new = modem_lines(wdata_i[4:0]);
  assign dlt_new   = {lines_now[3] ^ lines_new[3], lines_now[2] & ~lines_new[2],
                      lines_now[1] ^ lines_new[1], lines_now[0] ^ lines_new[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q       <= DIV_RST[7:0];
      dlh_q       <= DIV_RST[15:8];
      lcr_q       <= '0;
      scr_q       <= '0;
      fcr_q       <= '0;
      ier_q       <= '0;
      mcr_q       <= '0;
      msr_dlt_q   <= '0;
      thre_pend_q <= 1'b0;
      oe_q        <= 1'b0;
      tx_valid_q  <= 1'b0;
      tx_data_q   <= '0;
    end else begin
      tx_valid_q <= wr_data && !loop_en;
      if (wr_data && !loop_en) tx_data_q <= wdata_i;
      if (wr_i && hit) begin
        unique case (ofs)
          OFS_DATA: if (dlab) dll_q <= wdata_i;
          OFS_IER:  if (dlab) dlh_q <= wdata_i; else ier_q <= wdata_i[3:0];
          OFS_IIR:  fcr_q <= wdata_i[0] ? (wdata_i & FCR_KEEP) : 8'h00;
          OFS_LCR:  lcr_q <= wdata_i;
          OFS_MCR:  mcr_q <= wdata_i[4:0];
          OFS_SCR:  scr_q <= wdata_i;
          default:  ;
        endcase
      end
      if (wr_data)                        thre_pend_q <= 1'b1;
      else if (rd_iir && iid == IID_THRE) thre_pend_q <= 1'b0;
      if (q_drop)      oe_q <= 1'b1;
      else if (rd_lsr) oe_q <= 1'b0;
      if (wr_mcr)      msr_dlt_q <= msr_dlt_q | dlt_new;
      else if (rd_msr) msr_dlt_q <= '0;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;

  always_comb begin
    rdata_o = 8'h00;
    if (hit) begin
      unique case (ofs)
        OFS_DATA: rdata_o = dlab ? dll_q : (q_empty ? 8'h00 : q_head);
        OFS_IER:  rdata_o = dlab ? dlh_q : {4'h0, ier_q};
        OFS_IIR:  rdata_o = {fifo_en, fifo_en, 2'b00, iid};
        OFS_LCR:  rdata_o = lcr_q;
        OFS_MCR:  rdata_o = {3'b000, mcr_q};
        OFS_LSR:  rdata_o = {1'b0, 1'b1, 1'b1, 3'b000, oe_q, !q_empty};
        OFS_MSR:  rdata_o = {lines_now, msr_dlt_q};
        OFS_SCR:  rdata_o = scr_q;
        default:  rdata_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CW     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic              rd_i,
  input logic [7:0]        rdata_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic              irq_o,
  input logic              dlab,
  input logic              loop_en,
  input logic              fifo_en,
  input logic              thre_pend_q,
  input logic [CW-1:0]     q_count,
  input logic [CW-1:0]     q_cap
);
  logic data_wr;
  assign data_wr = wr_i && addr_i == ADDR_W'(0) && !dlab;

  assert_ier_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(1) && !dlab |-> rdata_o[7:4] == 4'h0);

  assert_iir_fifo_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(2) |-> rdata_o[7:6] == {2{fifo_en}});

  assert_thre_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !wr_i && addr_i == ADDR_W'(2) && rdata_o[3:0] == 4'h2 |=> !thre_pend_q);

  assert_lsr_tx_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(5) |-> rdata_o[6:5] == 2'b11);

  assert_lsr_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(5) |-> rdata_o[0] == (q_count != '0));

  assert_tx_after_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !loop_en |=> tx_valid_o && tx_data_o == $past(wdata_i));

  assert_no_tx_in_loop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && loop_en |=> !tx_valid_o);

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_count <= q_cap);

  assert_irq_matches_iid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == ADDR_W'(2) |-> irq_o == (rdata_o[3:0] != 4'h1));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .CW(QCW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_i        (wr_i),
  .wdata_i     (wdata_i),
  .rd_i        (rd_i),
  .rdata_o     (rdata_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .irq_o       (irq_o),
  .dlab        (dlab),
  .loop_en     (loop_en),
  .fifo_en     (fifo_en),
  .thre_pend_q (thre_pend_q),
  .q_count     (q_count),
  .q_cap       (q_cap)
);

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rx_push_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_regif uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .rdata_o(rdata_o), .rx_push_i(rx_push_i), .rx_data_i(rx_data_i),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .irq_o(irq_o)
  );

  // {is_read, offset, write data or expected read, requirement number}
  localparam int NV = 21;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h03, 8'h80, 8'd1},   // R1 divisor access on
    {1'b1, 8'h00, 8'h0C, 8'd9},   // R9 divisor low after reset
    {1'b1, 8'h01, 8'h00, 8'd9},   // R9 divisor high after reset
    {1'b0, 8'h00, 8'h34, 8'd1},
    {1'b0, 8'h01, 8'h12, 8'd1},
    {1'b1, 8'h00, 8'h34, 8'd1},
    {1'b1, 8'h01, 8'h12, 8'd1},
    {1'b0, 8'h03, 8'h03, 8'd1},   // R1 divisor access off
    {1'b1, 8'h03, 8'h03, 8'd1},
    {1'b0, 8'h01, 8'hFF, 8'd2},
    {1'b1, 8'h01, 8'h0F, 8'd2},   // R2 upper bits dropped
    {1'b1, 8'h02, 8'h01, 8'd3},   // R3 nothing pending
    {1'b1, 8'h05, 8'h60, 8'd6},   // R6 idle line status
    {1'b0, 8'h07, 8'hA5, 8'd1},
    {1'b1, 8'h07, 8'hA5, 8'd1},
    {1'b1, 8'h06, 8'hA0, 8'd14},  // R14 reset modem status
    {1'b0, 8'h01, 8'h02, 8'd4},
    {1'b0, 8'h00, 8'h41, 8'd4},   // R4 data write sets flag
    {1'b1, 8'h02, 8'h02, 8'd4},
    {1'b1, 8'h02, 8'h01, 8'd4},   // R4 cleared by previous read
    {1'b1, 8'h09, 8'h00, 8'd1}    // R1 out-of-range offset
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] got;
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 got = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
    chk(req, got, exp);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk_i); rx_data_i = b; rx_push_i = 1'b1;
    @(negedge clk_i); rx_push_i = 1'b0;
  endtask

  // read and external push in one cycle
  task automatic rd_push(input logic [7:0] a, input logic [7:0] b, input logic [7:0] exp, input string req);
    logic [7:0] got;
    @(negedge clk_i); addr_i = a; rd_i = 1'b1; rx_data_i = b; rx_push_i = 1'b1;
    #1 got = rdata_o;
    @(negedge clk_i); rd_i = 1'b0; rx_push_i = 1'b0;
    chk(req, got, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 reset irq", {7'b0, irq_o}, 8'h00);
    chk("R9 reset tx strobe", {7'b0, tx_valid_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) rd(VEC[i][23:16], VEC[i][15:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
      else            wr(VEC[i][23:16], VEC[i][15:8]);
    end

    // R13 transmit port, R12 interrupt level
    wr(8'h00, 8'h5A);
    chk("R13 strobe", {7'b0, tx_valid_o}, 8'h01);
    chk("R13 data", tx_data_o, 8'h5A);
    chk("R12 thre irq", {7'b0, irq_o}, 8'h01);
    @(negedge clk_i);
    chk("R13 single cycle", {7'b0, tx_valid_o}, 8'h00);
    rd(8'h02, 8'h02, "R4");
    chk("R12 irq low", {7'b0, irq_o}, 8'h00);

    // one-entry queue, overrun priority
    wr(8'h01, 8'h05);
    push(8'h11);
    rd(8'h05, 8'h61, "R6");
    chk("R12 rx irq", {7'b0, irq_o}, 8'h01);
    push(8'h22);
    rd(8'h02, 8'h06, "R3");
    rd(8'h05, 8'h63, "R9");
    rd(8'h05, 8'h61, "R6");
    rd(8'h02, 8'h04, "R3");
    rd(8'h00, 8'h11, "R11");
    rd(8'h05, 8'h60, "R11");
    rd(8'h02, 8'h01, "R3");

    // same-cycle pop/push and clear/set
    push(8'h11);
    rd_push(8'h00, 8'h22, 8'h11, "R11");
    rd(8'h05, 8'h61, "R11");
    rd_push(8'h05, 8'h33, 8'h61, "R6");
    rd(8'h05, 8'h63, "R6");
    rd(8'h00, 8'h22, "R11");
    rd(8'h05, 8'h60, "R11");

    // FIFO mode, full depth
    wr(8'h02, 8'h01);
    rd(8'h02, 8'hC1, "R5");
    for (int i = 0; i < 17; i++) push(8'h30 + 8'(i));
    rd(8'h05, 8'h63, "R11");
    for (int i = 0; i < 16; i++) rd(8'h00, 8'h30 + 8'(i), "R7");
    rd(8'h05, 8'h60, "R7");

    // FIFO control field handling
    push(8'hAA);
    push(8'hBB);
    wr(8'h02, 8'hC9);
    rd(8'h05, 8'h61, "R8");
    wr(8'h02, 8'h03);
    rd(8'h05, 8'h60, "R8");
    rd(8'h02, 8'hC1, "R5");
    push(8'hCC);
    wr(8'h02, 8'h00);
    rd(8'h05, 8'h60, "R7");
    rd(8'h02, 8'h01, "R5");
    push(8'h01);
    push(8'h02);
    rd(8'h05, 8'h63, "R7");
    rd(8'h00, 8'h01, "R7");
    push(8'h03);
    wr(8'h02, 8'h02);
    rd(8'h05, 8'h61, "R8");
    rd(8'h00, 8'h03, "R8");

    // modem status and loopback
    wr(8'h01, 8'h08);
    wr(8'h04, 8'h10);
    rd(8'h02, 8'h00, "R14");
    chk("R12 modem irq", {7'b0, irq_o}, 8'h01);
    rd(8'h06, 8'h0A, "R14");
    rd(8'h06, 8'h00, "R14");
    rd(8'h02, 8'h01, "R3");
    wr(8'h04, 8'h13);
    rd(8'h06, 8'h33, "R14");
    wr(8'h01, 8'h01);
    wr(8'h00, 8'h77);
    chk("R10 no transmit", {7'b0, tx_valid_o}, 8'h00);
    rd(8'h05, 8'h61, "R10");
    chk("R12 loop rx irq", {7'b0, irq_o}, 8'h01);
    push(8'h99);
    rd(8'h05, 8'h61, "R10");
    rd(8'h00, 8'h77, "R10");
    rd(8'h05, 8'h60, "R10");
    wr(8'h04, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule